// File: doc/BRIEF.md
# Slave-Select Override and Polarity Unit

This unit produces the eight slave-select pins of a serial peripheral master. In normal operation the command engine names one line (a 3-bit index plus an active flag) and the unit drives that line to its active level while every other line rests at its inactive level. Each line has its own polarity bit, so active-low and active-high slaves can share the bus. Software can take any line away from the engine through an override enable with a matching override level. The one exception is line 7, which serves an internal device and always follows the engine.

Configuration arrives through a plain register-write port with two words. The global word holds the per-line polarity, a clock-gate enable and the idle level for the data-out line. The override word holds the per-line enables and levels. The unit also produces a serial-clock enable. When gating is turned on, this enable drops whenever no select line is at its active level. The number of lines built is a parameter. A value above eight is clamped to eight, and unbuilt lines stay inactive. All outputs are registered. A write and an engine change both reach the pins at the next rising clock edge.

Top module: `cs_ovr_unit`

## Requirements
- R1: After reset all eight select pins are high, the serial-clock enable is 1 and the data-out idle level is 0. These are the outputs that follow from polarity, override and gate values of zero.
- R2: With no override in effect, an active engine command with index i drives line i to its active level one edge later. All other lines are at their inactive level.
- R3: Bit i of the global word (bits 7:0) is the polarity of line i. A 1 makes high the active level and a 0 makes low the active level. The inactive level is the inverse of the polarity bit.
- R4: Bit i of the override word (bits 7:0) enables the override for line i. While that bit is set, the line drives bit 8+i of the same word as its physical level and ignores the engine.
- R5: Line 7 ignores its override enable and level. It always follows the engine command and its polarity.
- R6: When bit 16 of the global word is set, the serial-clock enable is 1 only in cycles where at least one select pin is at its active level. When bit 16 is clear, the enable is always 1.
- R7: Bit 18 of the global word appears on the data-out idle level output one edge after it is written.
- R8: Lines at or above the configured count stay at their inactive level, whatever the engine or the override does. A configured count above eight behaves exactly as eight.
- R9: A register write (address 0 selects the global word, address 1 the override word) and an engine change take effect on the pins together at the next rising edge. No extra cycle is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | 0 selects the global word, 1 selects the override word |
| cfg_wdata_i | input | 32 | Write data |
| eng_active_i | input | 1 | Engine command is selecting a slave |
| eng_sel_i | input | 3 | Index of the slave the engine selects |
| ss_o | output | 8 | Physical slave-select pins |
| sclk_en_o | output | 1 | Serial clock enable |
| mosi_idle_o | output | 1 | Idle level for the data-out line |

## Verification
Every result of this unit is due exactly one rising edge after the stimulus that causes it. This holds for the pins, the clock enable and the idle level, and it holds both for a register write and for an engine change. The bench drives inputs just after a falling edge. It lets one rising edge pass and compares every output at the following falling edge against a behavioural model that has applied the same stimulus. The stimulus is applied to two instances, one configured with twelve lines (clamped to eight) and one with five. Directed phases cover each requirement, and a pseudo-random phase then mixes writes with engine commands.

// File: rtl/cs_ovr_pkg.sv
package cs_ovr_pkg;
  localparam int MAX_CS   = 8;
  localparam int SEL_W    = $clog2(MAX_CS);
  localparam int INT_IDX  = 7;
  localparam int POL_LSB  = 0;
  localparam int GATE_BIT = 16;
  localparam int MOSI_BIT = 18;
  localparam int OEN_LSB  = 0;
  localparam int OVAL_LSB = 8;

  typedef enum logic {
    CFG_GLOBAL   = 1'b0,
    CFG_OVERRIDE = 1'b1
  } cfg_addr_e;

  typedef struct packed {
    logic              mosi_idle;
    logic              gate;
    logic [MAX_CS-1:0] pol;
  } glob_cfg_t;

  typedef struct packed {
    logic [MAX_CS-1:0] val;
    logic [MAX_CS-1:0] en;
  } ovr_cfg_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_ovr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output glob_cfg_t   glob_q_o,
  output glob_cfg_t   glob_nx_o,
  output ovr_cfg_t    ovr_q_o,
  output ovr_cfg_t    ovr_nx_o
);
  glob_cfg_t glob_q;
  ovr_cfg_t  ovr_q;
  glob_cfg_t glob_nx;
  ovr_cfg_t  ovr_nx;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:19], wdata_i[17]};

  // next values are forwarded so a write reaches the pins in the same edge
  always_comb begin
    glob_nx = glob_q;
    ovr_nx  = ovr_q;
    if (wr_i && (addr_i == CFG_GLOBAL)) begin
      glob_nx.pol       = wdata_i[POL_LSB +: MAX_CS];
      glob_nx.gate      = wdata_i[GATE_BIT];
      glob_nx.mosi_idle = wdata_i[MOSI_BIT];
    end
    if (wr_i && (addr_i == CFG_OVERRIDE)) begin
      ovr_nx.en  = wdata_i[OEN_LSB +: MAX_CS];
      ovr_nx.val = wdata_i[OVAL_LSB +: MAX_CS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
      ovr_q  <= '0;
    end else begin
      glob_q <= glob_nx;
      ovr_q  <= ovr_nx;
    end
  end

  assign glob_q_o  = glob_q;
  assign glob_nx_o = glob_nx;
  assign ovr_q_o   = ovr_q;
  assign ovr_nx_o  = ovr_nx;
endmodule

// File: rtl/cs_hit_decode.sv
module cs_hit_decode
  import cs_ovr_pkg::*;
(
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [MAX_CS-1:0] hit_o
);
  always_comb begin
    hit_o = '0;
    for (int i = 0; i < MAX_CS; i++) begin
      hit_o[i] = active_i && (sel_i == SEL_W'(i));
    end
  end
endmodule

// File: rtl/cs_line_sel.sv
module cs_line_sel #(
  parameter int IDX     = 0,
  parameter bit LINE_EN = 1'b1,
  parameter bit NO_OVR  = 1'b0
) (
  input  logic pol_i,
  input  logic oen_i,
  input  logic oval_i,
  input  logic hit_i,
  output logic pin_o,
  output logic act_o
);
  localparam bit TAKE_OVR_OK = !NO_OVR;
  logic take_ovr;
  logic unused_idx;

  assign unused_idx = (IDX < 0);
  assign take_ovr   = TAKE_OVR_OK && oen_i;

  generate
    if (LINE_EN) begin : g_live
      always_comb begin
        if (take_ovr)   pin_o = oval_i;
        else if (hit_i) pin_o = pol_i;
        else            pin_o = ~pol_i;
      end
    end else begin : g_parked
      logic unused_in;
      assign unused_in = take_ovr ^ oval_i ^ hit_i;
      assign pin_o     = ~pol_i;
    end
  endgenerate

  assign act_o = (pin_o == pol_i);
endmodule

// File: rtl/cs_ovr_unit.sv
module cs_ovr_unit
  import cs_ovr_pkg::*;
#(
  parameter int NUM_CS_CFG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_i,
  input  logic        cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        eng_active_i,
  input  logic [2:0]  eng_sel_i,
  output logic [7:0]  ss_o,
  output logic        sclk_en_o,
  output logic        mosi_idle_o
);
  localparam int NUM_CS = (NUM_CS_CFG > MAX_CS) ? MAX_CS : NUM_CS_CFG;

  glob_cfg_t glob_q, glob_nx;
  ovr_cfg_t  ovr_q, ovr_nx;
  logic [MAX_CS-1:0] hit;
  logic [MAX_CS-1:0] pin_d;
  logic [MAX_CS-1:0] act_d;
  logic [MAX_CS-1:0] ss_q;
  logic              sclk_en_q;
  logic              sclk_en_d;

  cs_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cfg_wr_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .glob_q_o (glob_q),
    .glob_nx_o(glob_nx),
    .ovr_q_o  (ovr_q),
    .ovr_nx_o (ovr_nx)
  );

  cs_hit_decode u_dec (
    .active_i(eng_active_i),
    .sel_i   (eng_sel_i),
    .hit_o   (hit)
  );

  for (genvar i = 0; i < MAX_CS; i++) begin : g_line
    cs_line_sel #(
      .IDX    (i),
      .LINE_EN(i < NUM_CS),
      .NO_OVR (i == INT_IDX)
    ) u_line (
      .pol_i (glob_nx.pol[i]),
      .oen_i (ovr_nx.en[i]),
      .oval_i(ovr_nx.val[i]),
      .hit_i (hit[i]),
      .pin_o (pin_d[i]),
      .act_o (act_d[i])
    );
  end

  assign sclk_en_d = !glob_nx.gate || (|act_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q      <= '1;
      sclk_en_q <= 1'b1;
    end else begin
      ss_q      <= pin_d;
      sclk_en_q <= sclk_en_d;
    end
  end

  assign ss_o        = ss_q;
  assign sclk_en_o   = sclk_en_q;
  assign mosi_idle_o = glob_q.mosi_idle;
endmodule

// File: rtl/cs_ovr_unit_chk.sv
module cs_ovr_unit_chk
  import cs_ovr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        eng_active_i,
  input logic [2:0]  eng_sel_i,
  input logic [7:0]  ss_o,
  input logic        sclk_en_o,
  input glob_cfg_t   glob_q,
  input ovr_cfg_t    ovr_q
);
  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q.en == '0) |-> $onehot0(ss_o ^ ~glob_q.pol));

  assert_line0_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q.en[0] |-> (ss_o[0] == ovr_q.val[0]));

  assert_internal_no_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_active_i && (eng_sel_i == 3'd7)) |=> (ss_o[7] == ~glob_q.pol[7]));

  assert_free_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q.gate |-> sclk_en_o);

  assert_gated_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_q.gate && (ss_o == ~glob_q.pol)) |-> !sclk_en_o);
endmodule

bind cs_ovr_unit cs_ovr_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eng_active_i(eng_active_i),
  .eng_sel_i   (eng_sel_i),
  .ss_o        (ss_o),
  .sclk_en_o   (sclk_en_o),
  .glob_q      (glob_q),
  .ovr_q       (ovr_q)
);

// File: tb/cs_ovr_unit_tb.sv
module cs_ovr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        eng_active = 1'b0;
  logic [2:0]  eng_sel = '0;
  logic [7:0]  ss_a, ss_b;
  logic        sclk_a, sclk_b, mosi_a, mosi_b;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // model state
  logic [7:0] m_pol = '0, m_oen = '0, m_oval = '0;
  logic       m_gate = 1'b0, m_mosi = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  cs_ovr_unit #(.NUM_CS_CFG(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .eng_active_i(eng_active), .eng_sel_i(eng_sel),
    .ss_o(ss_a), .sclk_en_o(sclk_a), .mosi_idle_o(mosi_a));

  cs_ovr_unit #(.NUM_CS_CFG(5)) dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .eng_active_i(eng_active), .eng_sel_i(eng_sel),
    .ss_o(ss_b), .sclk_en_o(sclk_b), .mosi_idle_o(mosi_b));

  function automatic logic [7:0] model_pins(int n, logic act, logic [2:0] idx);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (i >= n)                     r[i] = ~m_pol[i];
      else if (m_oen[i] && i != 7)    r[i] = m_oval[i];
      else if (act && idx == 3'(i))   r[i] = m_pol[i];
      else                            r[i] = ~m_pol[i];
    end
    return r;
  endfunction

  function automatic logic model_sclk(logic [7:0] pins);
    return !m_gate || ((pins ^ ~m_pol) != 8'h00);
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic step(string tag, logic wr, logic addr, logic [31:0] data,
                      logic act, logic [2:0] idx);
    logic [7:0] ea, eb;
    cfg_wr = wr; cfg_addr = addr; cfg_wdata = data;
    eng_active = act; eng_sel = idx;
    if (wr && !addr) begin
      m_pol = data[7:0]; m_gate = data[16]; m_mosi = data[18];
    end
    if (wr && addr) begin
      m_oen = data[7:0]; m_oval = data[15:8];
    end
    ea = model_pins(8, act, idx);
    eb = model_pins(5, act, idx);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(tag, "pins(8)", ss_a, ea);
    chk(tag, "sclk(8)", {7'd0, sclk_a}, {7'd0, model_sclk(ea)});
    chk(tag, "mosi(8)", {7'd0, mosi_a}, {7'd0, m_mosi});
    chk(tag, "pins(5)", ss_b, eb);
    chk(tag, "sclk(5)", {7'd0, sclk_b}, {7'd0, model_sclk(eb)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "pins", ss_a, 8'hFF);
    chk("R1", "sclk", {7'd0, sclk_a}, 8'd1);
    chk("R1", "mosi", {7'd0, mosi_a}, 8'd0);
    chk("R1", "pins(5)", ss_b, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: engine walks every index, active-low lines
    for (int i = 0; i < 8; i++) step("R2", 1'b0, 1'b0, 32'h0, 1'b1, 3'(i));
    step("R2", 1'b0, 1'b0, 32'h0, 1'b0, 3'd3);

    // R3: mixed polarity
    step("R3", 1'b1, 1'b0, 32'h0000_00A5, 1'b0, 3'd0);
    for (int i = 0; i < 8; i++) step("R3", 1'b0, 1'b0, 32'h0, 1'b1, 3'(i));

    // R4: override on lines 0..3, engine on overridden and free lines
    step("R4", 1'b1, 1'b1, 32'h0000_050F, 1'b1, 3'd1);
    step("R4", 1'b0, 1'b0, 32'h0, 1'b1, 3'd4);
    step("R4", 1'b0, 1'b0, 32'h0, 1'b1, 3'd2);
    step("R4", 1'b1, 1'b1, 32'h0000_F0F0, 1'b0, 3'd0);

    // R5: override of line 7 is ignored
    step("R5", 1'b1, 1'b1, 32'h0000_0080, 1'b0, 3'd0);
    step("R5", 1'b1, 1'b1, 32'h0000_8080, 1'b1, 3'd7);
    step("R5", 1'b0, 1'b0, 32'h0, 1'b0, 3'd7);

    // R6: clock gating
    step("R6", 1'b1, 1'b1, 32'h0, 1'b0, 3'd0);
    step("R6", 1'b1, 1'b0, 32'h0001_0000, 1'b0, 3'd0);
    step("R6", 1'b0, 1'b0, 32'h0, 1'b1, 3'd2);
    step("R6", 1'b0, 1'b0, 32'h0, 1'b0, 3'd2);
    step("R6", 1'b1, 1'b1, 32'h0000_0001, 1'b0, 3'd0);
    step("R6", 1'b1, 1'b1, 32'h0, 1'b1, 3'd6);

    // R7: data-out idle level
    step("R7", 1'b1, 1'b0, 32'h0004_0000, 1'b0, 3'd0);
    step("R7", 1'b1, 1'b0, 32'h0000_0000, 1'b0, 3'd0);

    // R8: lines beyond the configured count, and clamp of 12 to 8
    step("R8", 1'b1, 1'b1, 32'h0000_00E0, 1'b1, 3'd5);
    step("R8", 1'b1, 1'b1, 32'h0, 1'b1, 3'd6);
    step("R8", 1'b0, 1'b0, 32'h0, 1'b1, 3'd7);

    // R9: write and engine change land on the same edge
    step("R9", 1'b1, 1'b0, 32'h0001_00FF, 1'b1, 3'd0);
    step("R9", 1'b1, 1'b1, 32'h0000_0001, 1'b1, 3'd3);
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = {lfsr[3:0], 9'd0, lfsr[5], 1'b0, lfsr[6], lfsr[15:0]};
      step("R9", lfsr[7] & lfsr[8], lfsr[9], d, lfsr[10], lfsr[13:11]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule